// File: doc/BRIEF.md
# Latched-Address Byte-Write SRAM

A single-port static memory whose address, chip-select and write-data inputs each pass through a level-sensitive holding stage. When a holding stage's enable is high, its input goes straight through, combinationally. When the enable is low, the stage keeps the value it had at the last clock edge at which the enable was high. With both enables tied high, the block acts as a plain SRAM. Reads are combinational from the effective address, and writes commit at the rising clock edge.

The word is split into two halves of `HALF_W` bits, and each half has its own active-low write strobe, so partial-word writes are possible. The full-size part uses `ADDR_W = 15`, which gives 32,768 words of 18 bits. The default of 10 keeps elaboration small.

The access decoder has four states, chosen combinationally from the effective controls:

- **ACC_OFF**: the effective select is inactive.
- **ACC_WRITE**: the block is selected and a strobe is low.
- **ACC_READ**: the block is selected, no strobe is low and output enable is low.
- **ACC_IDLE**: the block is selected, no strobe is low and output enable is high.

The decoder has the following transitions:

- **sel_drop**: any state to ACC_OFF, when the select goes inactive.
- **strobe**: to ACC_WRITE, with priority over output enable.
- **oe_on**: ACC_IDLE to ACC_READ.
- **oe_off**: ACC_READ to ACC_IDLE.
- **strobe_end**: ACC_WRITE to ACC_READ or ACC_IDLE.

Top module: `latched_sram`

## Requirements
- R1: The memory holds 2**ADDR_W words of 2*HALF_W bits, and every address up to the last one is writable and readable. After reset, the held chip select is inactive (1), the held address is 0 and the held data is 0.
- R2: While `addr_le` is high, `addr` and `cs_n` reach the array directly, so a read reflects a new address in the same cycle.
- R3: While `addr_le` is low, the address and select are the values held from the last rising edge at which `addr_le` was high. Changes on the raw `addr` and `cs_n` have no effect on reads or writes.
- R4: While `data_le` is high, `wdata` is written directly. While it is low, the written value is the one held from the last rising edge at which `data_le` was high.
- R5: With both latch enables high, a write followed by a read of the same address returns the written word.
- R6: `wr_lo_n` low writes bits [HALF_W-1:0] only, at the rising edge, and leaves the upper half unchanged.
- R7: `wr_hi_n` low writes bits [2*HALF_W-1:HALF_W] only, at the rising edge, and leaves the lower half unchanged.
- R8: Both strobes low together write the whole word.
- R9: `rd_valid` is 1 only while the effective select is 0, `oe_n` is 0 and both strobes are 1. In that case `rdata` is the word at the effective address; otherwise `rdata` is 0.
- R10: While the effective select is 1, strobes write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock: holding stages capture and writes commit on the rising edge |
| rst_n | input | 1 | Active-low reset of the holding stages |
| addr | input | ADDR_W | Raw word address |
| cs_n | input | 1 | Raw active-low chip select, held together with the address |
| addr_le | input | 1 | Address/select holding-stage enable, high means pass-through |
| data_le | input | 1 | Write-data holding-stage enable, high means pass-through |
| wr_lo_n | input | 1 | Active-low write strobe, lower half |
| wr_hi_n | input | 1 | Active-low write strobe, upper half |
| oe_n | input | 1 | Active-low output enable |
| wdata | input | 2*HALF_W | Raw write data |
| rdata | output | 2*HALF_W | Read data, zero while not driven |
| rd_valid | output | 1 | High when the data bus would be driven |

## Verification
A held address stage that leaks the raw address shows up at `rdata` in the same cycle the raw address moves with `addr_le` low. It also shows up one edge later, as a write landing on the wrong word. A wrong write-data hold appears on the first read of the word written with `data_le` low. A strobe steering the wrong half appears on the next read, as a changed neighbour half. An access-state decode error shows at once as a wrong `rd_valid`.

// File: rtl/latched_sram_pkg.sv
package latched_sram_pkg;
    typedef enum logic [1:0] {
        ACC_OFF   = 2'd0,
        ACC_IDLE  = 2'd1,
        ACC_READ  = 2'd2,
        ACC_WRITE = 2'd3
    } acc_state_t;
endpackage

// File: rtl/hold_stage.sv
module hold_stage #(
    parameter int         W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            held <= RST_VAL;
        else if (en)
            held <= d;
    end

    assign q = en ? d : held;

    // R3 / R4: a closed stage keeps its output across an edge
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (en || $stable(q)));
endmodule

// File: rtl/halfword_array.sv
module halfword_array #(
    parameter int ADDR_W = 10,
    parameter int HALF_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [2*HALF_W-1:0] wdata,
    output logic [2*HALF_W-1:0] rdata
);
    localparam int WORD_W = 2 * HALF_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int h = 0; h < 2; h++) begin
            if (we[h])
                mem[addr][h*HALF_W +: HALF_W] <= wdata[h*HALF_W +: HALF_W];
        end
    end

    assign rdata = mem[addr];

    // R6: lower strobe stores the lower half
    p_lo_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we[0] |=> mem[$past(addr)][HALF_W-1:0] == $past(wdata[HALF_W-1:0]));
    // R6: lower-only write keeps the upper half
    p_lo_keeps_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we[0] && !we[1]) |=> mem[$past(addr)][WORD_W-1:HALF_W] == $past(mem[addr][WORD_W-1:HALF_W]));
    // R7: upper strobe stores the upper half
    p_hi_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we[1] |=> mem[$past(addr)][WORD_W-1:HALF_W] == $past(wdata[WORD_W-1:HALF_W]));
    // R7: upper-only write keeps the lower half
    p_hi_keeps_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we[1] && !we[0]) |=> mem[$past(addr)][HALF_W-1:0] == $past(mem[addr][HALF_W-1:0]));
endmodule

// File: rtl/latched_sram.sv
module latched_sram
    import latched_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int HALF_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  cs_n,
    input  logic                  addr_le,
    input  logic                  data_le,
    input  logic                  wr_lo_n,
    input  logic                  wr_hi_n,
    input  logic                  oe_n,
    input  logic [2*HALF_W-1:0]   wdata,
    output logic [2*HALF_W-1:0]   rdata,
    output logic                  rd_valid
);
    localparam int WORD_W = 2 * HALF_W;
    localparam int CTL_W  = ADDR_W + 1;

    logic [CTL_W-1:0]  ctl_q;
    logic [ADDR_W-1:0] eff_addr;
    logic              eff_cs_n;
    logic [WORD_W-1:0] eff_wdata;
    logic [WORD_W-1:0] arr_rdata;
    logic [1:0]        we;
    acc_state_t        acc_state;

    hold_stage #(.W(CTL_W), .RST_VAL({1'b1, {ADDR_W{1'b0}}})) u_addr_hold (
        .clk (clk),
        .rst_n (rst_n),
        .en  (addr_le),
        .d   ({cs_n, addr}),
        .q   (ctl_q)
    );

    assign eff_cs_n = ctl_q[CTL_W-1];
    assign eff_addr = ctl_q[ADDR_W-1:0];

    hold_stage #(.W(WORD_W), .RST_VAL('0)) u_data_hold (
        .clk (clk),
        .rst_n (rst_n),
        .en  (data_le),
        .d   (wdata),
        .q   (eff_wdata)
    );

    // access state decode
    always_comb begin
        if (eff_cs_n)
            acc_state = ACC_OFF;
        else if (!wr_lo_n || !wr_hi_n)
            acc_state = ACC_WRITE;
        else if (!oe_n)
            acc_state = ACC_READ;
        else
            acc_state = ACC_IDLE;
    end

    // per-state outputs
    always_comb begin
        we       = 2'b00;
        rd_valid = 1'b0;
        unique case (acc_state)
            ACC_OFF:   ;
            ACC_IDLE:  ;
            ACC_READ:  rd_valid = 1'b1;
            ACC_WRITE: we = {~wr_hi_n, ~wr_lo_n};
            default:   ;
        endcase
    end

    halfword_array #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .addr  (eff_addr),
        .wdata (eff_wdata),
        .rdata (arr_rdata)
    );

    assign rdata = rd_valid ? arr_rdata : '0;

    // R9: no data while a strobe is low or output is disabled
    p_bus_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo_n || !wr_hi_n || oe_n) |-> (!rd_valid && rdata == '0));
    // R10: a deselected access never writes
    p_no_write_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eff_cs_n |-> (we == 2'b00));
    // R3: while closed, the effective address does not follow the raw one
    p_addr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_le && $past(!addr_le)) |-> $stable(eff_addr));
endmodule

// File: tb/latched_sram_test.sv
module latched_sram_test;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 10;
    localparam int HALF_W = 9;
    localparam int WORD_W = 2 * HALF_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              cs_n = 1'b1;
    logic              addr_le = 1'b0;
    logic              data_le = 1'b0;
    logic              wr_lo_n = 1'b1;
    logic              wr_hi_n = 1'b1;
    logic              oe_n = 1'b1;
    logic [WORD_W-1:0] wdata = '0;
    logic [WORD_W-1:0] rdata;
    logic              rd_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    latched_sram #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n),
        .addr_le(addr_le), .data_le(data_le), .wr_lo_n(wr_lo_n),
        .wr_hi_n(wr_hi_n), .oe_n(oe_n), .wdata(wdata),
        .rdata(rdata), .rd_valid(rd_valid)
    );

    // reference model
    logic [WORD_W-1:0] ref_mem [1 << ADDR_W];
    logic [ADDR_W-1:0] h_addr;
    logic              h_cs_n;
    logic [WORD_W-1:0] h_data;

    typedef struct packed {
        logic ale; logic dle; logic cs; logic wl; logic wh; logic oe;
        logic [9:0] a; logic [17:0] d; logic en; logic [3:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{1,1,0,0,0,1, 10'd5,    18'h2A5A5, 0, 4'd8},  // R8 full write
        '{1,1,0,1,1,0, 10'd5,    18'h00000, 1, 4'd8},  // R8 read back
        '{1,1,0,0,0,1, 10'd9,    18'h1F0F0, 0, 4'd8},
        '{1,1,0,0,1,1, 10'd5,    18'h3FFFF, 0, 4'd6},  // R6 lower only
        '{1,1,0,1,1,0, 10'd5,    18'h00000, 1, 4'd6},
        '{1,1,0,1,0,1, 10'd9,    18'h00000, 0, 4'd7},  // R7 upper only
        '{1,1,0,1,1,0, 10'd9,    18'h00000, 1, 4'd7},
        '{1,1,1,0,0,0, 10'd5,    18'h12345, 0, 4'd10}, // R10 deselected
        '{1,1,0,1,1,0, 10'd5,    18'h00000, 1, 4'd10},
        '{1,1,0,1,1,1, 10'd5,    18'h00000, 0, 4'd9},  // R9 oe high
        '{1,1,0,0,0,0, 10'd12,   18'h0ABCD, 0, 4'd9},  // R9 write with oe low
        '{1,1,0,1,1,0, 10'd12,   18'h00000, 1, 4'd5},  // R5
        '{1,1,0,1,1,0, 10'd9,    18'h00000, 1, 4'd2},  // R2
        '{0,1,0,1,1,0, 10'd5,    18'h00000, 1, 4'd3},  // R3 raw addr moves
        '{0,1,1,1,1,0, 10'd12,   18'h00000, 1, 4'd3},  // R3 raw cs high
        '{0,1,1,0,0,1, 10'd5,    18'h15555, 0, 4'd3},  // R3 write to held addr
        '{0,1,1,1,1,0, 10'd12,   18'h00000, 1, 4'd3},
        '{1,1,0,1,1,1, 10'd20,   18'h2AAAA, 0, 4'd4},  // R4 capture data
        '{1,0,0,0,0,1, 10'd20,   18'h00011, 0, 4'd4},  // R4 held data used
        '{1,1,0,1,1,0, 10'd20,   18'h00000, 1, 4'd4},
        '{1,1,0,0,0,1, 10'd1023, 18'h3FFFF, 0, 4'd1},  // R1 last word
        '{1,1,0,1,1,0, 10'd1023, 18'h00000, 1, 4'd1}
    };

    task automatic check(input bit ok, input int req, input logic [WORD_W-1:0] act,
                         input logic [WORD_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] eff_a();
        return addr_le ? addr : h_addr;
    endfunction

    // verify outputs, then model the coming edge
    task automatic step(input logic exp_en, input int req);
        logic [ADDR_W-1:0] ea;
        logic              ec;
        logic [WORD_W-1:0] ed;
        #(CLK_P/4);
        ea = eff_a();
        ec = addr_le ? cs_n : h_cs_n;
        ed = data_le ? wdata : h_data;
        check(rd_valid === exp_en, req, {17'b0, rd_valid}, {17'b0, exp_en});
        if (exp_en)
            check(rdata === ref_mem[ea], req, rdata, ref_mem[ea]);
        else
            check(rdata === '0, req, rdata, '0);
        @(posedge clk);
        if (!ec && !wr_lo_n) ref_mem[ea][HALF_W-1:0] = ed[HALF_W-1:0];
        if (!ec && !wr_hi_n) ref_mem[ea][WORD_W-1:HALF_W] = ed[WORD_W-1:HALF_W];
        if (addr_le) begin h_addr = addr; h_cs_n = cs_n; end
        if (data_le) h_data = wdata;
        @(negedge clk);
    endtask

    initial begin
        h_addr = '0; h_cs_n = 1'b1; h_data = '0;
        repeat (3) @(negedge clk);
        // R1: reset state, held select inactive
        oe_n = 1'b0;
        #(CLK_P/4);
        check(rd_valid === 1'b0, 1, {17'b0, rd_valid}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1);

        for (int i = 0; i < NV; i++) begin
            addr_le = TBL[i].ale; data_le = TBL[i].dle; cs_n = TBL[i].cs;
            wr_lo_n = TBL[i].wl;  wr_hi_n = TBL[i].wh;  oe_n = TBL[i].oe;
            addr = TBL[i].a;      wdata = TBL[i].d;
            step(TBL[i].en, int'(TBL[i].req));
        end

        // R5: both enables high, address change seen without a clock edge
        addr_le = 1'b1; data_le = 1'b1; cs_n = 1'b0; oe_n = 1'b0;
        wr_lo_n = 1'b1; wr_hi_n = 1'b1; addr = 10'd5;
        #(CLK_P/8);
        check(rdata === ref_mem[5], 5, rdata, ref_mem[5]);
        addr = 10'd1023;
        #(CLK_P/8);
        check(rdata === ref_mem[1023], 5, rdata, ref_mem[1023]);
        @(negedge clk);

        // R2: raw select high in pass-through blocks the read at once
        cs_n = 1'b1;
        #(CLK_P/8);
        check(rd_valid === 1'b0, 2, {17'b0, rd_valid}, '0);
        @(negedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule